// File: doc/BRIEF.md
# Quad-Line Flash Read Front End

This block is the device side of a serial flash read path. Clock modes 0 and 3 are supported. After chip select falls, the host sends an 8-bit opcode one bit per clock on line 0. It then sends a 24-bit byte address and an 8-bit mode byte, four bits per clock, on lines 3 down to 0. With no idle clocks in between, the block turns the four lines around and streams bytes from an attached byte source, four bits per clock. Inputs are sampled on the rising clock edge. Outputs are launched on the falling edge.

The mode byte decides how the next chip-select cycle begins. If bits 5:4 of the mode byte equal binary 10, the following cycle skips the opcode and starts directly with the address. Any other value returns the block to opcode-first operation.

A request is refused when the quad-enable status input is low, when the opcode is unknown, or when the address is not aligned to 16 bytes. A refused request leaves the lines released until chip select rises. The skip-opcode state can be cleared in two ways: by the opcode 0xFF in normal operation, or by four all-ones nibbles while the block is in skip-opcode operation.

Top module: `qio_read_front`

## Requirements
- R1: While rst_ni is low, and while cs_ni is high, io_oe_o is 0.
- R2: The opcode is taken MSB first from io_i[0] over 8 rising edges. Opcode 0xE3 with quad_en_i high moves the block into the address phase.
- R3: The address (6 nibbles, MSB nibble first) and the mode byte (2 nibbles, high nibble first) follow on io_i[3:0] with no dummy clocks. io_oe_o stays 0 until the falling edge that comes right after the rising edge sampling the last mode nibble. At that falling edge the first data nibble appears.
- R4: Data bytes are taken from mem_data_i at mem_addr_o, high nibble first. The address starts at the received value, rises by one per byte, and wraps from 0xFFFFFF to 0x000000.
- R5: Opcode 0xE3 received while quad_en_i is low produces no output until cs_ni rises.
- R6: An address whose bits 3:0 are not all zero produces no output until cs_ni rises.
- R7: Mode bits 5:4 equal to binary 10 make the next chip-select cycle begin at the address phase, with no opcode. Mode bits 3:0 have no effect.
- R8: Any other value of mode bits 5:4 makes the next cycle expect the opcode again.
- R9: In opcode-first operation, opcode 0xFF produces no output and keeps opcode-first operation. In skip-opcode operation, the first four address nibbles all equal to 0xF end the cycle with no output and return the block to opcode-first operation.
- R10: A rise of cs_ni at any point clears io_oe_o at once and restarts the sequence on the next falling edge of cs_ni.
- R11: Any opcode other than 0xE3 and 0xFF produces no output until cs_ni rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| quad_en_i | input | 1 | Quad-enable status bit |
| io_i | input | 4 | Values sampled from the four IO lines |
| io_o | output | 4 | Data driven onto the IO lines |
| io_oe_o | output | 1 | Output enable for the IO lines |
| mem_addr_o | output | 24 | Byte address to the byte source |
| mem_data_i | input | 8 | Byte returned by the byte source for mem_addr_o |

## Verification
The bench builds the block with its default parameters: a 24-bit address, opcode 0xE3 for the read and 0xFF for the mode clear. With these values, a 17-byte burst from 0xFFFFF0 reaches the address wrap. The bench also covers the 16-bit all-ones clear pattern in skip-opcode operation. The byte source is modelled as a fold of the address bits, so every byte in a burst carries a checkable value.

// File: rtl/qio_pkg.sv
package qio_pkg;
  typedef enum logic [2:0] {
    ST_START,
    ST_CMD,
    ST_ADDR,
    ST_MODE,
    ST_DATA,
    ST_ABORT
  } qio_state_e;
endpackage

// File: rtl/qio_seq_ctrl.sv
module qio_seq_ctrl
  import qio_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter logic [7:0]  CMD_READ = 8'hE3,
  parameter logic [7:0]  CMD_MRST = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              quad_en_i,
  input  logic [3:0]        io_i,
  output logic              data_phase_o,
  output logic              half_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int ADDR_NIB = ADDR_W / 4;
  localparam int CNT_W    = $clog2(ADDR_NIB > 8 ? ADDR_NIB : 8);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIB - 1);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(7);
  localparam logic [CNT_W-1:0] MRST_LAST = CNT_W'(3);

  qio_state_e        state_q, cur;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] sh_q, addr_q;
  logic [1:0]        mode_q;
  logic              half_q, cont_q;

  logic [ADDR_W-1:0] nib_shift;
  logic [7:0]        cmd_byte;
  logic              mrst_hit, mode_done;

  // first edge of a cycle picks the phase from the saved mode
  always_comb begin
    cur = state_q;
    if (state_q == ST_START) cur = cont_q ? ST_ADDR : ST_CMD;
  end

  assign nib_shift = {sh_q[ADDR_W-5:0], io_i};
  assign cmd_byte  = {sh_q[6:0], io_i[0]};
  assign mrst_hit  = (cur == ST_ADDR) && cont_q && (cnt_q == MRST_LAST) &&
                     ({sh_q[11:0], io_i} == 16'hFFFF);
  assign mode_done = (cur == ST_MODE) && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni or posedge cs_ni) begin
    if (!rst_ni || cs_ni) begin
      state_q <= ST_START;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      mode_q  <= '0;
      half_q  <= 1'b0;
    end else begin
      unique case (cur)
        ST_CMD: begin
          sh_q <= {sh_q[ADDR_W-2:0], io_i[0]};
          if (cnt_q == CMD_LAST) begin
            cnt_q   <= '0;
            state_q <= (cmd_byte == CMD_READ && quad_en_i) ? ST_ADDR : ST_ABORT;
          end else begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= ST_CMD;
          end
        end
        ST_ADDR: begin
          sh_q <= nib_shift;
          if (mrst_hit) begin
            state_q <= ST_ABORT;
          end else if (cnt_q == ADDR_LAST) begin
            cnt_q   <= '0;
            addr_q  <= nib_shift;
            state_q <= (io_i == 4'h0) ? ST_MODE : ST_ABORT;
          end else begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= ST_ADDR;
          end
        end
        ST_MODE: begin
          if (mode_done) begin
            state_q <= ST_DATA;
            half_q  <= 1'b0;
          end else begin
            mode_q  <= io_i[1:0];
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          half_q <= ~half_q;
          if (half_q) addr_q <= addr_q + 1'b1;
        end
        default: state_q <= ST_ABORT;
      endcase
    end
  end

  // skip-opcode flag survives chip-select cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cont_q <= 1'b0;
    end else if (!cs_ni) begin
      if (mode_done)     cont_q <= (mode_q == 2'b10);
      else if (mrst_hit) cont_q <= 1'b0;
    end
  end

  assign data_phase_o = (state_q == ST_DATA);
  assign half_o       = half_q;
  assign addr_o       = addr_q;

  assert_qe_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    (state_q == ST_ADDR && $past(state_q) == ST_CMD) |-> $past(quad_en_i));
  assert_abort_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    (state_q == ST_ABORT) |=> (state_q == ST_ABORT));
  assert_addr_aligned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    (state_q == ST_MODE && $past(state_q) == ST_ADDR) |-> ($past(io_i) == 4'h0));
  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    (state_q == ST_DATA && half_q) |=> (addr_q == $past(addr_q) + 1'b1));
  assert_cont_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cont_q != $past(cont_q)) |-> ($past(state_q) == ST_MODE || $past(state_q) == ST_ADDR));
endmodule

// File: rtl/qio_nib_drv.sv
module qio_nib_drv (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       data_phase_i,
  input  logic       half_i,
  input  logic [7:0] byte_i,
  output logic [3:0] io_o,
  output logic       io_oe_o
);
  always_ff @(negedge clk_i or negedge rst_ni or posedge cs_ni) begin
    if (!rst_ni || cs_ni) begin
      io_oe_o <= 1'b0;
      io_o    <= '0;
    end else begin
      io_oe_o <= data_phase_i;
      io_o    <= half_i ? byte_i[3:0] : byte_i[7:4];
    end
  end

  assert_oe_in_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || cs_ni)
    io_oe_o |-> data_phase_i);
  assert_cs_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !io_oe_o);
endmodule

// File: rtl/qio_read_front.sv
module qio_read_front #(
  parameter int         ADDR_W   = 24,
  parameter logic [7:0] CMD_READ = 8'hE3,
  parameter logic [7:0] CMD_MRST = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              quad_en_i,
  input  logic [3:0]        io_i,
  output logic [3:0]        io_o,
  output logic              io_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i
);
  logic data_phase, half;

  qio_seq_ctrl #(
    .ADDR_W   (ADDR_W),
    .CMD_READ (CMD_READ),
    .CMD_MRST (CMD_MRST)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_ni        (cs_ni),
    .quad_en_i    (quad_en_i),
    .io_i         (io_i),
    .data_phase_o (data_phase),
    .half_o       (half),
    .addr_o       (mem_addr_o)
  );

  qio_nib_drv u_drv (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_ni        (cs_ni),
    .data_phase_i (data_phase),
    .half_i       (half),
    .byte_i       (mem_data_i),
    .io_o         (io_o),
    .io_oe_o      (io_oe_o)
  );
endmodule

// File: tb/qio_read_front_test.sv
module qio_read_front_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        qe = 1'b1;
  logic [3:0]  io_in = '0;
  logic [3:0]  io_out;
  logic        io_oe;
  logic [23:0] mem_addr;
  logic [7:0]  mem_data;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] membyte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  assign mem_data = membyte(mem_addr);

  qio_read_front uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .quad_en_i(qe),
    .io_i(io_in), .io_o(io_out), .io_oe_o(io_oe),
    .mem_addr_o(mem_addr), .mem_data_i(mem_data)
  );

  typedef struct packed {
    logic        skip;
    logic [23:0] addr;
    logic [7:0]  mode;
    logic [4:0]  nb;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{1'b0, 24'h000010, 8'h20, 5'd3},
    '{1'b1, 24'h001230, 8'hA5, 5'd2},
    '{1'b1, 24'h0ABCF0, 8'h00, 5'd2},
    '{1'b0, 24'hFFFFF0, 8'hF0, 5'd17},
    '{1'b0, 24'h000100, 8'h6C, 5'd2}
  };

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic cs_end();
    @(negedge clk); cs_n = 1'b1; io_in = '0;
    #5 chk(!io_oe, "R10", {7'b0, io_oe}, 8'h00);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); cs_n = 1'b0; io_in = {3'b000, c[i]};
    end
  endtask

  task automatic send_nib(input logic [3:0] n);
    @(negedge clk); cs_n = 1'b0; io_in = n;
  endtask

  task automatic send_addr_mode(input logic [23:0] a, input logic [7:0] m);
    for (int i = 5; i >= 0; i--) send_nib(a[i*4 +: 4]);
    send_nib(m[7:4]);
    send_nib(m[3:0]);
  endtask

  task automatic read_check(input logic [23:0] a, input int nb, input string req);
    #5 chk(!io_oe, "R3", {7'b0, io_oe}, 8'h00);
    for (int b = 0; b < nb; b++) begin
      logic [7:0] e;
      e = membyte(a + 24'(b));
      @(negedge clk); io_in = '0;
      #5 chk(io_oe && io_out == e[7:4], req, {3'b0, io_oe, io_out}, {4'h1, e[7:4]});
      @(negedge clk);
      #5 chk(io_oe && io_out == e[3:0], req, {3'b0, io_oe, io_out}, {4'h1, e[3:0]});
    end
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); io_in = '0;
      #5 chk(!io_oe, req, {7'b0, io_oe}, 8'h00);
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=%h exp=%h", 8'h00, 8'h01);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #15 chk(!io_oe, "R1", {7'b0, io_oe}, 8'h00);
    #30 rst_n = 1'b1;
    quiet(2, "R1");

    // vector walk: R2 R3 R4 R7 R8
    foreach (VEC[k]) begin
      if (!VEC[k].skip) send_cmd(8'hE3);
      send_addr_mode(VEC[k].addr, VEC[k].mode);
      read_check(VEC[k].addr, int'(VEC[k].nb), VEC[k].skip ? "R7" : "R4");
      cs_end();
    end

    // skip-opcode active: all-ones nibbles clear it (R9)
    for (int i = 0; i < 4; i++) send_nib(4'hF);
    quiet(3, "R9");
    cs_end();
    send_cmd(8'hE3);
    send_addr_mode(24'h000200, 8'h00);
    read_check(24'h000200, 1, "R9");
    cs_end();

    // opcode 0xFF in normal operation (R9)
    send_cmd(8'hFF);
    quiet(4, "R9");
    cs_end();
    send_cmd(8'hE3);
    send_addr_mode(24'h000300, 8'h30);
    read_check(24'h000300, 1, "R9");
    cs_end();

    // mode 0x30 left opcode-first: bare address is refused (R8)
    send_addr_mode(24'h000040, 8'h00);
    quiet(4, "R8");
    cs_end();

    // quad enable clear (R5)
    qe = 1'b0;
    send_cmd(8'hE3);
    send_addr_mode(24'h000050, 8'h00);
    quiet(4, "R5");
    cs_end();
    qe = 1'b1;

    // misaligned address (R6)
    send_cmd(8'hE3);
    send_addr_mode(24'h000013, 8'h00);
    quiet(4, "R6");
    cs_end();

    // unknown opcode (R11)
    send_cmd(8'hEB);
    send_addr_mode(24'h000060, 8'h00);
    quiet(4, "R11");
    cs_end();

    // chip select raised mid-address, then a fresh cycle (R10)
    send_cmd(8'hE3);
    send_nib(4'h1); send_nib(4'h2); send_nib(4'h3);
    cs_end();
    send_cmd(8'hE3);
    send_addr_mode(24'h000070, 8'h00);
    read_check(24'h000070, 1, "R10");
    @(negedge clk); cs_n = 1'b1;
    #5 chk(!io_oe, "R10", {7'b0, io_oe}, 8'h00);
    @(negedge clk); @(negedge clk);
    send_cmd(8'hE3);
    send_addr_mode(24'h000080, 8'h00);
    read_check(24'h000080, 2, "R2");
    cs_end();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule